// File: doc/BRIEF.md
# Run-Length Proactive Unit Allocator

This block sits behind the merged undervoltage trigger of a ten-unit interleaved switched-capacitor stack regulator. It samples the trigger bit once per control clock. From that stream it decides how many units leave trigger-driven switching and join a free-running proactive group. A run of consecutive trigger ones means the single-bound loop is struggling, so one more unit becomes proactive. A run of consecutive zeros means load has eased, so one unit returns to trigger control. A run that is broken by a value change counts for nothing. This gives the allocation hysteresis against a chattering trigger.

The proactive units are taken from the top index downward, and unit 0 always stays under trigger control. Each proactive unit toggles its phase bit once per ten-cycle frame, in its own slot of that frame. The units are therefore interleaved and run at the maximum per-unit rate. The proactive mask feeds the trigger rotator so that the rotator skips those units. The mask is reloaded only at the frame boundary, so a unit never toggles twice within one frame.

Top module: `pa_alloc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the proactive count, `pro_mask` and `pro_phase` all become zero. The frame slot restarts at 0 in the first cycle after release.
- R2: Every `one_run_thr` consecutive samples of `trig_in` = 1 raise the proactive count by one. The run counter then restarts, so a run of N ones gives floor(N / threshold) steps. A threshold of 0 acts as 1. A run one sample shorter than the threshold gives no step.
- R3: Every `zero_run_thr` consecutive samples of `trig_in` = 0 lower the proactive count by one, under the same restart rule as R2.
- R4: A change in the value of `trig_in` restarts the run at length 1. A trigger that alternates every cycle, with both thresholds at 2 or more, never changes the count.
- R5: The count saturates at 0 and at UNITS-1 (9). Bit 0 of `pro_mask` is never set.
- R6: `pro_mask` is a top-down thermometer: with count c, bits [UNITS-1 : UNITS-c] are set and all others are clear.
- R7: `pro_mask` loads the count only at the edge that ends frame slot UNITS-1. These are edges 10, 20, 30 and so on after reset release. A count change made by the sample at edge k is visible at the first such edge at or after edge k+2.
- R8: During frame slot i (edge n after release with (n-1) mod 10 = i), a unit i that is set in `pro_mask` toggles `pro_phase[i]`. At most one phase bit changes per edge, and each proactive unit toggles exactly once per ten cycles.
- R9: A unit that is clear in `pro_mask` holds its `pro_phase` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock (one frame slot per cycle) |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Merged undervoltage trigger sample |
| one_run_thr | input | RUN_W (8) | Run of ones needed to add a proactive unit |
| zero_run_thr | input | RUN_W (8) | Run of zeros needed to drop a proactive unit |
| pro_mask | output | UNITS (10) | Units handed to the proactive group |
| pro_phase | output | UNITS (10) | Phase bits driven for proactive units |

## Verification
The bench runs a run of ones exactly one sample short of the threshold, and then one that reaches it. A comparator that is off by one, or a run counter that fails to restart on a value change, would then add a unit too early or too late. An alternating trigger must leave the count alone; a design without hysteresis would drift. Long runs drive the count into both rails, where a design without saturation would wrap and set unit 0. With nine units active, the bench watches a full frame for exactly one toggle per unit and per cycle, and it tracks the edges at which the mask changes. A design that reloads the mask mid-frame would show a change away from a frame boundary or a double toggle. A design that let idle units run would move a phase bit outside the mask.

// File: rtl/pa_alloc_pkg.sv
// Package: shared types for the proactive unit allocator.
// Assumes: a single control clock domain.
package pa_alloc_pkg;

    // One-cycle request from the run detector to the count register.
    typedef struct packed {
        logic up;
        logic down;
    } pa_step_t;

endpackage

// File: rtl/pa_run_detect.sv
// Module: pa_run_detect
// Measures runs of equal trigger samples. When a run reaches the threshold
// for its value, it issues a one-cycle up (ones) or down (zeros) request and
// restarts the run. A change of value restarts the run at length 1.
// Assumes: thresholds are quasi-static; a zero threshold behaves as 1.
module pa_run_detect
    import pa_alloc_pkg::*;
#(
    parameter int unsigned RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [RUN_W-1:0] one_thr,
    input  logic [RUN_W-1:0] zero_thr,
    output pa_step_t         step
);

    logic             last_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;
    logic [RUN_W-1:0] thr_sel;
    logic             hit;
    pa_step_t         step_q;

    // Length of the run including this sample, and the threshold test.
    always_comb begin
        run_nxt = (trig == last_q) ? run_q + RUN_W'(1) : RUN_W'(1);
        thr_sel = trig ? one_thr : zero_thr;
        hit     = (run_nxt >= thr_sel);
    end

    // Run state and registered step request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            run_q  <= '0;
            step_q <= '0;
        end else begin
            last_q      <= trig;
            run_q       <= hit ? '0 : run_nxt;
            step_q.up   <= hit & trig;
            step_q.down <= hit & ~trig;
        end
    end

    assign step = step_q;

endmodule

// File: rtl/pa_count.sv
// Module: pa_count
// Saturating count of proactive units, moved by one per step request.
// Assumes: up and down are never requested in the same cycle.
module pa_count
    import pa_alloc_pkg::*;
#(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned MAX_CNT = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pa_step_t         step,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    // Clamp to the range 0 .. MAX_CNT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step.up && (count_q < CNT_W'(MAX_CNT))) begin
            count_q <= count_q + CNT_W'(1);
        end else if (step.down && (count_q != '0)) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/pa_phase_gen.sv
// Module: pa_phase_gen
// Frame slot counter, mask reload at the frame boundary, and staggered
// phase toggles: unit i toggles in slot i while it is proactive.
// Assumes: UNITS slots per frame, one slot per clock.
module pa_phase_gen #(
    parameter int unsigned UNITS  = 10,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count,
    output logic [UNITS-1:0]  mask,
    output logic [UNITS-1:0]  phase,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(UNITS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [UNITS-1:0]  mask_q;
    logic [UNITS-1:0]  want_mask;
    logic [UNITS-1:0]  phase_q;
    logic              frame_end;

    assign frame_end = (slot_q == LAST_SLOT);

    // Top-down thermometer for the requested count.
    always_comb begin
        for (int i = 0; i < int'(UNITS); i++) begin
            want_mask[i] = ((i + int'(count)) >= int'(UNITS));
        end
    end

    // Slot counter and boundary-only mask reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            mask_q <= '0;
        end else begin
            slot_q <= frame_end ? '0 : slot_q + SLOT_W'(1);
            if (frame_end) begin
                mask_q <= want_mask;
            end
        end
    end

    // One toggle flop per unit, fired in its own slot.
    for (genvar g = 0; g < int'(UNITS); g++) begin : g_unit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                phase_q[g] <= 1'b0;
            end else if ((slot_q == SLOT_W'(g)) && mask_q[g]) begin
                phase_q[g] <= ~phase_q[g];
            end
        end
    end

    assign mask  = mask_q;
    assign phase = phase_q;
    assign slot  = slot_q;

endmodule

// File: rtl/pa_alloc.sv
// Module: pa_alloc (top)
// Sizes the proactive group from trigger run lengths and drives its phases.
// Assumes: trig_in is already synchronous to clk.
module pa_alloc
    import pa_alloc_pkg::*;
#(
    parameter int unsigned UNITS = 10,
    parameter int unsigned RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic [RUN_W-1:0] one_run_thr,
    input  logic [RUN_W-1:0] zero_run_thr,
    output logic [UNITS-1:0] pro_mask,
    output logic [UNITS-1:0] pro_phase
);

    localparam int unsigned CNT_W   = $clog2(UNITS);
    localparam int unsigned SLOT_W  = $clog2(UNITS);
    localparam int unsigned MAX_CNT = UNITS - 1;

    pa_step_t          run_step;
    logic [CNT_W-1:0]  pro_count;
    logic [SLOT_W-1:0] frame_slot;

    pa_run_detect #(.RUN_W(RUN_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_in),
        .one_thr  (one_run_thr),
        .zero_thr (zero_run_thr),
        .step     (run_step)
    );

    pa_count #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (run_step),
        .count (pro_count)
    );

    pa_phase_gen #(.UNITS(UNITS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .count (pro_count),
        .mask  (pro_mask),
        .phase (pro_phase),
        .slot  (frame_slot)
    );

endmodule

// File: rtl/pa_alloc_chk.sv
// Module: pa_alloc_chk
// Property checker for pa_alloc, attached through bind.
// Assumes: connected to the top's count and frame slot.
module pa_alloc_chk #(
    parameter int unsigned UNITS  = 10,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [UNITS-1:0]  pro_mask,
    input logic [UNITS-1:0]  pro_phase,
    input logic [CNT_W-1:0]  count,
    input logic [SLOT_W-1:0] slot
);

    logic             live_q;
    logic [UNITS-1:0] idle_units;

    // Marks that the previous edge was out of reset.
    always_ff @(posedge clk) begin
        live_q <= rst_n;
    end

    assign idle_units = ~pro_mask;

    p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= int'(UNITS) - 1);

    p_unit0_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pro_mask[0]);

    p_therm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_units & (idle_units + UNITS'(1))) == '0);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((int'(count) == int'($past(count))) ||
                    (int'(count) == int'($past(count)) + 1) ||
                    (int'(count) + 1 == int'($past(count)))));

    p_mask_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (pro_mask != $past(pro_mask))) |->
            (int'($past(slot)) == int'(UNITS) - 1));

    p_one_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ($countones(pro_phase ^ $past(pro_phase)) <= 1));

    for (genvar g = 0; g < int'(UNITS); g++) begin : g_unit_chk
        p_slot_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && (pro_phase[g] != $past(pro_phase[g]))) |->
                (int'($past(slot)) == g));

        p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && !$past(pro_mask[g])) |-> $stable(pro_phase[g]));
    end

endmodule

bind pa_alloc pa_alloc_chk #(.UNITS(UNITS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pro_mask  (pro_mask),
    .pro_phase (pro_phase),
    .count     (pro_count),
    .slot      (frame_slot)
);

// File: tb/pa_alloc_test.sv
`timescale 1ns/1ps
// Bench for pa_alloc: a segment table against a cycle model, then directed
// tests for threshold edges, stagger, boundaries and reset.
module pa_alloc_test;

    localparam int CLK_PERIOD = 10;
    localparam int UNITS      = 10;
    localparam int RUN_W      = 8;
    localparam int SKIP       = 15;

    typedef struct packed {
        logic [1:0] kind;   // 0 zeros, 1 ones, 2 alternate starting with 1
        logic [7:0] len;
        logic [3:0] exp_pop;
    } seg_t;

    localparam seg_t SEGS [8] = '{
        '{2'd0, 8'd60, 4'd0},
        '{2'd1, 8'd6,  4'd15},
        '{2'd2, 8'd40, 4'd2},
        '{2'd1, 8'd60, 4'd9},
        '{2'd2, 8'd40, 4'd9},
        '{2'd0, 8'd10, 4'd15},
        '{2'd2, 8'd40, 4'd7},
        '{2'd0, 8'd60, 4'd0}
    };

    logic             clk;
    logic             rst_n;
    logic             trig;
    logic [RUN_W-1:0] one_thr;
    logic [RUN_W-1:0] zero_thr;
    logic [UNITS-1:0] pro_mask;
    logic [UNITS-1:0] pro_phase;

    int total;
    int bad;
    int seg_err;
    int r7_bad;
    int r9_bad;
    int edges;

    pa_alloc #(.UNITS(UNITS), .RUN_W(RUN_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_in      (trig),
        .one_run_thr  (one_thr),
        .zero_run_thr (zero_thr),
        .pro_mask     (pro_mask),
        .pro_phase    (pro_phase)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycle model written from the requirements.
    logic             m_last;
    int               m_run;
    logic             m_up;
    logic             m_dn;
    int               m_cnt;
    int               m_slot;
    logic [UNITS-1:0] m_mask;
    logic [UNITS-1:0] m_phase;
    int               mv_nxt;
    int               mv_thr;
    logic             mv_hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_last <= 1'b0; m_run <= 0; m_up <= 1'b0; m_dn <= 1'b0;
            m_cnt <= 0; m_slot <= 0; m_mask <= '0; m_phase <= '0;
            edges <= 0;
        end else begin
            edges  <= edges + 1;
            mv_nxt = (trig == m_last) ? m_run + 1 : 1;
            mv_thr = trig ? int'(one_thr) : int'(zero_thr);
            if (mv_thr < 1) mv_thr = 1;
            mv_hit = (mv_nxt >= mv_thr);
            m_last <= trig;
            m_run  <= mv_hit ? 0 : mv_nxt;
            m_up   <= mv_hit && trig;
            m_dn   <= mv_hit && !trig;
            if (m_up && m_cnt < UNITS - 1) m_cnt <= m_cnt + 1;
            else if (m_dn && m_cnt > 0)    m_cnt <= m_cnt - 1;
            m_slot <= (m_slot == UNITS - 1) ? 0 : m_slot + 1;
            if (m_slot == UNITS - 1)
                for (int i = 0; i < UNITS; i++) m_mask[i] <= (i >= UNITS - m_cnt);
            for (int i = 0; i < UNITS; i++)
                if (m_slot == i && m_mask[i]) m_phase[i] <= ~m_phase[i];
        end
    end

    // Away-from-edge monitor: model compare, boundary (R7) and hold (R9).
    logic [UNITS-1:0] prev_mask;
    logic [UNITS-1:0] prev_phase;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_mask  <= '0;
            prev_phase <= '0;
        end else begin
            if (pro_mask !== m_mask || pro_phase !== m_phase) seg_err++;
            if (pro_mask != prev_mask && (edges % 10) != 0) r7_bad++;
            for (int i = 0; i < UNITS; i++)
                if (!prev_mask[i] && pro_phase[i] != prev_phase[i]) r9_bad++;
            prev_mask  <= pro_mask;
            prev_phase <= pro_phase;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive_const(input logic v, input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            trig = v;
        end
    endtask

    task automatic drive_alt(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            trig = (c % 2 == 0);
        end
    endtask

    task automatic settle_point();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int tog [UNITS];
        int multi;
        logic [UNITS-1:0] pv;
        total = 0; bad = 0; seg_err = 0; r7_bad = 0; r9_bad = 0;
        rst_n = 1'b0; trig = 1'b0; one_thr = 8'd3; zero_thr = 8'd5;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(pro_mask == '0, "R1 mask in reset", int'(pro_mask), 0);
        chk(pro_phase == '0, "R1 phase in reset", int'(pro_phase), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 via model and popcount.
        for (int s = 0; s < 8; s++) begin
            seg_err = 0;
            if (SEGS[s].kind == 2'd2) drive_alt(int'(SEGS[s].len));
            else drive_const(SEGS[s].kind[0], int'(SEGS[s].len));
            settle_point();
            chk(seg_err == 0, "R2 R3 R6 model mismatch cycles", seg_err, 0);
            if (SEGS[s].exp_pop != 4'(SKIP))
                chk($countones(pro_mask) == int'(SEGS[s].exp_pop), "R4 R5 proactive count",
                    $countones(pro_mask), int'(SEGS[s].exp_pop));
        end

        // R2 boundary: three ones with threshold 4 add nothing, four add one.
        one_thr = 8'd4;
        drive_const(1'b1, 3); drive_const(1'b0, 1); drive_alt(30);
        settle_point();
        chk(pro_mask == '0, "R2 short run ignored", int'(pro_mask), 0);
        drive_const(1'b1, 4); drive_alt(30);
        settle_point();
        chk(pro_mask == 10'h200, "R2 R6 one unit from top", int'(pro_mask), 'h200);

        // R3 boundary: four zeros with threshold 5 remove nothing, five remove one.
        drive_const(1'b1, 1); drive_const(1'b0, 4); drive_alt(30);
        settle_point();
        chk(pro_mask == 10'h200, "R3 short run ignored", int'(pro_mask), 'h200);
        drive_const(1'b1, 1); drive_const(1'b0, 5); drive_alt(30);
        settle_point();
        chk(pro_mask == '0, "R3 unit returned", int'(pro_mask), 0);

        // R5 R8: saturate, then watch one full frame of staggered toggles.
        drive_const(1'b1, 60);
        settle_point();
        chk(pro_mask == 10'h3FE, "R5 saturated mask", int'(pro_mask), 'h3FE);
        for (int i = 0; i < UNITS; i++) tog[i] = 0;
        multi = 0;
        @(negedge clk);
        pv = pro_phase;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if ($countones(pro_phase ^ pv) > 1) multi++;
            if (c >= 10)
                for (int i = 0; i < UNITS; i++) if (pro_phase[i] != pv[i]) tog[i]++;
            pv = pro_phase;
        end
        chk(multi == 0, "R8 one phase change per cycle", multi, 0);
        chk(tog[0] == 0, "R5 unit 0 stays on trigger", tog[0], 0);
        for (int i = 1; i < UNITS; i++)
            chk(tog[i] == 1, "R8 one toggle per frame", tog[i], 1);

        // R7 R9: whole-run monitors.
        chk(r7_bad == 0, "R7 mask change off boundary", r7_bad, 0);
        chk(r9_bad == 0, "R9 idle phase moved", r9_bad, 0);

        // R1: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        settle_point();
        chk(pro_mask == '0, "R1 mask after mid reset", int'(pro_mask), 0);
        chk(pro_phase == '0, "R1 phase after mid reset", int'(pro_phase), 0);
        @(negedge clk);
        rst_n = 1'b1;
        seg_err = 0;
        drive_const(1'b1, 30);
        settle_point();
        chk(seg_err == 0, "R1 R7 restart after reset", seg_err, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule